// File: doc/BRIEF.md
# Two-Street Crossing Light Controller

This block drives the signal heads at a crossing of two streets, called street A and street B. A vehicle sensor on each street reports whether traffic is waiting or flowing there. Green stays on a street for as long as its sensor reports traffic. When the sensor goes quiet, that street shows yellow for one clock cycle. The other street then receives green. After its own sensor clears and its own single yellow cycle, green returns to street A.

The controller is a Moore machine with four states held in two flip-flops. The state codes and the light codes are fixed so that each light bit comes from at most one gate on the state bits. The lights therefore depend only on the registered state and change only at clock edges. There are no timers. The sensor inputs alone set how long each green phase lasts.

Top module: `crossing_light_ctrl`

## Requirements
- R1: `rst` is synchronous and active high, and it overrides both sensors. Every rising clock edge sampled with `rst` high leaves `light_a` = 00 (green) and `light_b` = 10 (red).
- R2: Light codes are green = 00, yellow = 01 and red = 10. While `light_a` is green and `light_b` is red, a sampled `sense_a` = 1 keeps both lights unchanged after the edge, whatever the value of `sense_b`.
- R3: While `light_a` is green, a sampled `sense_a` = 0 sets `light_a` to yellow (01) after the edge, with `light_b` still red, whatever the value of `sense_b`.
- R4: A-yellow lasts exactly one cycle and ignores both sensors. The next edge always gives `light_a` red (10) and `light_b` green (00).
- R5: While `light_b` is green, a sampled `sense_b` = 1 keeps both lights unchanged after the edge, whatever the value of `sense_a`.
- R6: While `light_b` is green, a sampled `sense_b` = 0 sets `light_b` to yellow (01) with `light_a` red. B-yellow lasts exactly one cycle and ignores both sensors, and the next edge returns `light_a` to green and `light_b` to red.
- R7: Outside reset, at least one of the two lights is red at all times, the two lights are never both non-red, and code 11 never appears on either light.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to A-green |
| sense_a | input | 1 | Traffic present on street A |
| sense_b | input | 1 | Traffic present on street B |
| light_a | output | 2 | Street A light code (00 green, 01 yellow, 10 red) |
| light_b | output | 2 | Street B light code (00 green, 01 yellow, 10 red) |

## Verification
The B-yellow phase is the hardest state to reach from the ports. The bench can only get there by dropping `sense_a`, passing through A-yellow, holding B-green and then dropping `sense_b`. Each state is a different number of such steps from reset. The stimulus therefore steers the machine from reset along that path to each of the four phases in turn and applies all four sensor combinations there. A reference model in the bench predicts the lights for every step. A long pseudo-random sensor sequence then exercises back-to-back transitions and resets issued in the middle of a phase.

// File: rtl/crossing_light_pkg.sv
package crossing_light_pkg;

    localparam int PHASE_W = 2;
    localparam int LIGHT_W = 2;

    // Binary phase codes; the light decode relies on these exact values.
    typedef enum logic [PHASE_W-1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_e;

    localparam logic [LIGHT_W-1:0] LAMP_GREEN  = 2'b00;
    localparam logic [LIGHT_W-1:0] LAMP_YELLOW = 2'b01;
    localparam logic [LIGHT_W-1:0] LAMP_RED    = 2'b10;

    typedef struct packed {
        phase_e phase;
    } ctrl_state_t;

endpackage

// File: rtl/cl_phase_step.sv
module cl_phase_step
    import crossing_light_pkg::*;
(
    input  phase_e cur,
    input  logic   sense_a,
    input  logic   sense_b,
    output phase_e nxt
);
    logic hi, lo;
    logic hi_n, lo_n;

    always_comb begin
        hi   = cur[1];
        lo   = cur[0];
        // Upper bit toggles whenever the lower bit is set.
        hi_n = hi ^ lo;
        // Lower bit sets only when a green phase loses its traffic.
        lo_n = (~hi & ~lo & ~sense_a) | (hi & ~lo & ~sense_b);
        nxt  = phase_e'({hi_n, lo_n});
    end
endmodule

// File: rtl/cl_lamp_decode.sv
module cl_lamp_decode
    import crossing_light_pkg::*;
(
    input  phase_e             cur,
    output logic [LIGHT_W-1:0] lamp_a,
    output logic [LIGHT_W-1:0] lamp_b
);
    always_comb begin
        lamp_a = {cur[1], ~cur[1] & cur[0]};
        lamp_b = {~cur[1], cur[1] & cur[0]};
    end
endmodule

// File: rtl/crossing_light_ctrl.sv
module crossing_light_ctrl
    import crossing_light_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sense_a,
    input  logic               sense_b,
    output logic [LIGHT_W-1:0] light_a,
    output logic [LIGHT_W-1:0] light_b
);
    ctrl_state_t st_d, st_q;
    phase_e      step_phase;

    cl_phase_step u_step (
        .cur     (st_q.phase),
        .sense_a (sense_a),
        .sense_b (sense_b),
        .nxt     (step_phase)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.phase = PH_A_GO;
        end else begin
            st_d.phase = step_phase;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    cl_lamp_decode u_lamp (
        .cur    (st_q.phase),
        .lamp_a (light_a),
        .lamp_b (light_b)
    );

    AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_GREEN && sense_a) |=> (light_a == LAMP_GREEN && light_b == LAMP_RED)); // R2
    AST_A_DROP: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_GREEN && !sense_a) |=> (light_a == LAMP_YELLOW)); // R3
    AST_A_WARN_ONCE: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_YELLOW) |=> (light_a == LAMP_RED && light_b == LAMP_GREEN)); // R4
    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        (light_b == LAMP_GREEN && sense_b) |=> (light_b == LAMP_GREEN && light_a == LAMP_RED)); // R5
    AST_B_WARN_ONCE: assert property (@(posedge clk) disable iff (rst)
        (light_b == LAMP_YELLOW) |=> (light_a == LAMP_GREEN && light_b == LAMP_RED)); // R6
    AST_ONE_RED: assert property (@(posedge clk) disable iff (rst)
        (light_a == LAMP_RED) || (light_b == LAMP_RED)); // R7
    AST_NO_CODE11: assert property (@(posedge clk) disable iff (rst)
        (light_a != 2'b11) && (light_b != 2'b11)); // R7

endmodule

// File: tb/crossing_light_ctrl_test.sv
module crossing_light_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sa = 1'b0, sb = 1'b0;
    logic [1:0] la, lb;
    int tests = 0, fails = 0;
    int model;       // 0 A-green, 1 A-yellow, 2 B-green, 3 B-yellow
    logic done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    crossing_light_ctrl uut (
        .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb),
        .light_a(la), .light_b(lb)
    );

    function automatic logic [1:0] exp_a(int s);
        return (s == 0) ? 2'b00 : (s == 1) ? 2'b01 : 2'b10;
    endfunction
    function automatic logic [1:0] exp_b(int s);
        return (s == 2) ? 2'b00 : (s == 3) ? 2'b01 : 2'b10;
    endfunction
    function automatic int step(int s, logic a, logic b);
        case (s)
            0: return a ? 0 : 1;
            1: return 2;
            2: return b ? 2 : 3;
            default: return 0;
        endcase
    endfunction
    function automatic string req(int s, logic r);
        if (r) return "R1";
        case (s)
            0: return "R2/R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string r);
        tests++;
        if (la !== exp_a(model) || lb !== exp_b(model)) begin
            fails++;
            $display("FAIL %s: lights A=%b B=%b expected A=%b B=%b",
                     r, la, lb, exp_a(model), exp_b(model));
        end
        tests++;  // R7: a red street at all times, no code 11
        if (!(la == 2'b10 || lb == 2'b10) || la == 2'b11 || lb == 2'b11) begin
            fails++;
            $display("FAIL R7: lights A=%b B=%b expected one red, no 11", la, lb);
        end
    endtask

    // Drive on the falling edge, check after the following rising edge.
    task automatic cyc(logic r, logic a, logic b, logic do_chk);
        string tag;
        @(negedge clk);
        rst = r; sa = a; sb = b;
        tag = req(model, r);
        model = r ? 0 : step(model, a, b);
        @(posedge clk); #1;
        if (do_chk) check(tag);
    endtask

    task automatic goto_phase(int target);
        cyc(1'b1, 1'b0, 1'b0, 1'b1);          // R1 reset check
        while (model != target) begin
            if (model == 0)      cyc(1'b0, 1'b0, 1'b1, 1'b0);
            else if (model == 2) cyc(1'b0, 1'b1, 1'b0, 1'b0);
            else                 cyc(1'b0, 1'b1, 1'b1, 1'b0);
        end
    endtask

    initial begin
        logic [7:0] lfsr;
        model = 0;
        cyc(1'b1, 1'b1, 1'b1, 1'b1);  // R1 reset with sensors active
        // Sweep every phase against every sensor pair.
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                goto_phase(p);
                cyc(1'b0, c[0], c[1], 1'b1);
                cyc(1'b0, c[0], c[1], 1'b1);
            end
        end
        // R1: reset from every phase, sensors asserted.
        for (int p = 0; p < 4; p++) begin
            goto_phase(p);
            cyc(1'b1, 1'b1, 1'b1, 1'b1);
        end
        // Long pseudo-random run with occasional resets.
        lfsr = 8'hA5;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[7:2] == 6'd0, lfsr[0], lfsr[1], 1'b1);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run incomplete, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule